// File: doc/BRIEF.md
# Edge-Triggered Word Stack with FIFO/LIFO Retrieval

This block holds up to a fixed number of 16-bit words and has two strobes: one stores a word and one retrieves a word. Each strobe acts once, on the clock cycle in which it is first seen high. A strobe that stays high does nothing further until it has gone low and risen again. A mode input chooses the retrieval order for each unload. In oldest-first order the word in slot 0 comes out, and every remaining word then moves down one slot. In newest-first order the word most recently stored comes out.

The block keeps a count of the words it holds and shows that count on its outputs, together with full and empty flags. An attempt to store into a full buffer, or to retrieve from an empty one, is rejected. A rejected attempt leaves the contents alone and sets an error flag. The error flag stays set until a synchronous clear. The retrieved word is held in a register, which changes only when a retrieval succeeds. The block suits part buffers on a production line: oldest-first order keeps a delay line in arrival order, and newest-first order models a pile.

Top module: `edge_word_stack`

## Requirements
- R1: After reset the count is 0, the empty flag is 1, the full flag is 0, the error flag is 0 and the output word is 0.
- R2: A store or retrieval happens only in the first cycle that its strobe is sampled high after being sampled low. Holding a strobe high has no further effect.
- R3: Successful stores fill slots in ascending order from slot 0. Each one raises the count by one. The full flag is 1 exactly when the count equals DEPTH, and the empty flag is 1 exactly when the count is 0.
- R4: With the mode input at 0 (oldest first), a retrieval outputs the word in slot 0. The remaining words shift down one slot, so later retrievals return them in arrival order. The count drops by one.
- R5: With the mode input at 1 (newest first), a retrieval outputs the word in the highest occupied slot and drops the count by one.
- R6: A store edge while the buffer is full, with no retrieval in the same cycle, sets the error flag. The count and the stored words stay unchanged.
- R7: A retrieval edge while the buffer is empty sets the error flag. The count stays 0 and the output word stays unchanged.
- R8: When store and retrieval edges arrive in the same cycle, the retrieval is done first and the store second. Both succeed when the buffer is full. Only the store succeeds when the buffer is empty.
- R9: The error flag stays set until a cycle with the clear input high. If a new rejection happens in that same cycle, the flag stays set.
- R10: The output word keeps its value in every cycle without a successful retrieval.
- R11: The mode input is sampled at each retrieval. Unloads in mixed order on one sequence of contents each return the word that their own mode selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loadStrobe | input | 1 | Store request; acts on its rising edge |
| unloadStrobe | input | 1 | Retrieve request; acts on its rising edge |
| lifoMode | input | 1 | 0 = oldest first, 1 = newest first |
| errClear | input | 1 | Synchronous clear of the error flag |
| srcWord | input | DATA_W | Word captured by a store |
| outWord | output | DATA_W | Last retrieved word |
| count | output | CNT_W | Number of words held |
| isFull | output | 1 | Count equals DEPTH |
| isEmpty | output | 1 | Count is zero |
| errFlag | output | 1 | Sticky flag for a rejected store or retrieval |

## Verification
The assertions assume that the strobes and the mode input are synchronous to the clock and hold steady across each rising edge. They also assume that reset is held long enough for the edge detectors to see both strobes low. The stimulus drives every input on the falling edge and keeps both strobes low during reset. Edges are therefore counted the same way by the design and by the reference model, and this still holds in the random phase where the strobes, the mode and the clear input change every cycle.

// File: rtl/stack_pkg.sv
package stack_pkg;
  // Command from control to datapath, valid for one cycle
  typedef struct packed {
    logic doLoad;    // accepted store this cycle
    logic doUnload;  // accepted retrieval this cycle
    logic lifoSel;   // retrieval order for this cycle
  } stackCmd_t;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadStrobe,
  input  logic             unloadStrobe,
  input  logic             lifoMode,
  input  logic             errClear,
  output stackCmd_t        cmd,
  output logic [CNT_W-1:0] count,
  output logic             isFull,
  output logic             isEmpty,
  output logic             errFlag
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             loadPrev, unloadPrev;
  logic             ldEdge, ulEdge, ulOk, ldOk, errSet;
  logic [CNT_W-1:0] cntAfterUl;

  assign ldEdge     = loadStrobe & ~loadPrev;
  assign ulEdge     = unloadStrobe & ~unloadPrev;
  // retrieval is resolved before the store in the same cycle
  assign ulOk       = ulEdge && (count != '0);
  assign cntAfterUl = count - CNT_W'(ulOk);
  assign ldOk       = ldEdge && (cntAfterUl != DEPTH_C);
  assign errSet     = (ulEdge && !ulOk) || (ldEdge && !ldOk);

  assign cmd     = '{doLoad: ldOk, doUnload: ulOk, lifoSel: lifoMode};
  assign isFull  = (count == DEPTH_C);
  assign isEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loadPrev   <= 1'b0;
      unloadPrev <= 1'b0;
      count      <= '0;
      errFlag    <= 1'b0;
    end else begin
      loadPrev   <= loadStrobe;
      unloadPrev <= unloadStrobe;
      count      <= cntAfterUl + CNT_W'(ldOk);
      if (errSet)        errFlag <= 1'b1;
      else if (errClear) errFlag <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C); // R3
  AST_HELD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStrobe && loadPrev && !ulEdge) |=> $stable(count)); // R2
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ldEdge && !ulEdge && isFull) |=> (errFlag && count == DEPTH_C)); // R6
  AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ulEdge && isEmpty) |=> errFlag); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !errClear) |=> errFlag); // R9
  AST_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ldEdge && ulEdge && isFull) |=> isFull); // R8
endmodule

// File: rtl/stack_data.sv
module stack_data
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 5,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stackCmd_t         cmd,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] srcWord,
  output logic [DATA_W-1:0] outWord
);
  logic [DATA_W-1:0] slotMem [DEPTH];
  logic [CNT_W-1:0]  readIdx, writeIdx;
  logic [DATA_W-1:0] readWord;
  logic              fifoShift;

  assign readIdx   = cmd.lifoSel ? (count - CNT_W'(1)) : '0;
  assign writeIdx  = count - CNT_W'(cmd.doUnload);
  assign fifoShift = cmd.doUnload && !cmd.lifoSel;

  always_comb begin
    readWord = '0;
    for (int k = 0; k < DEPTH; k++)
      if (readIdx == CNT_W'(k)) readWord = slotMem[k];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] shiftIn;
    if (i < DEPTH - 1) begin : g_mid
      assign shiftIn = slotMem[i+1];
    end else begin : g_top
      assign shiftIn = '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                   slotMem[i] <= '0;
      else if (cmd.doLoad && writeIdx == CNT_W'(i)) slotMem[i] <= srcWord;
      else if (fifoShift)                           slotMem[i] <= shiftIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            outWord <= '0;
    else if (cmd.doUnload) outWord <= readWord;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.doUnload |=> $stable(outWord)); // R10
  AST_FIFO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    fifoShift |=> (outWord == $past(slotMem[0]))); // R4
endmodule

// File: rtl/edge_word_stack.sv
module edge_word_stack
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 5,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadStrobe,
  input  logic              unloadStrobe,
  input  logic              lifoMode,
  input  logic              errClear,
  input  logic [DATA_W-1:0] srcWord,
  output logic [DATA_W-1:0] outWord,
  output logic [CNT_W-1:0]  count,
  output logic              isFull,
  output logic              isEmpty,
  output logic              errFlag
);
  stackCmd_t cmd;

  stack_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadStrobe(loadStrobe),
    .unloadStrobe(unloadStrobe), .lifoMode(lifoMode), .errClear(errClear),
    .cmd(cmd), .count(count), .isFull(isFull), .isEmpty(isEmpty),
    .errFlag(errFlag)
  );

  stack_data #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .count(count),
    .srcWord(srcWord), .outWord(outWord)
  );
endmodule

// File: tb/edge_word_stack_tb.sv
module edge_word_stack_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 5;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              loadStrobe = 1'b0, unloadStrobe = 1'b0;
  logic              lifoMode = 1'b0, errClear = 1'b0;
  logic [DATA_W-1:0] srcWord = '0;
  logic [DATA_W-1:0] outWord;
  logic [CNT_W-1:0]  count;
  logic              isFull, isEmpty, errFlag;

  int total = 0;
  int bad = 0;

  // behavioural reference
  int q[$];
  int mOut = 0;
  bit mErr = 0, mPrevLd = 0, mPrevUl = 0;

  always #4 clk = ~clk;

  edge_word_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .loadStrobe(loadStrobe),
    .unloadStrobe(unloadStrobe), .lifoMode(lifoMode), .errClear(errClear),
    .srcWord(srcWord), .outWord(outWord), .count(count), .isFull(isFull),
    .isEmpty(isEmpty), .errFlag(errFlag)
  );

  task automatic checkAll(input string tag);
    int  expCnt;
    bit  ok;
    expCnt = q.size();
    ok = (int'(count) == expCnt) && (isFull == (expCnt == DEPTH)) &&
         (isEmpty == (expCnt == 0)) && (errFlag == mErr) &&
         (int'(outWord) == mOut);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual cnt=%0d full=%0b empty=%0b err=%0b out=%h expected cnt=%0d full=%0b empty=%0b err=%0b out=%h",
               tag, count, isFull, isEmpty, errFlag, outWord,
               expCnt, expCnt == DEPTH, expCnt == 0, mErr, mOut[DATA_W-1:0]);
    end
  endtask

  task automatic step(input logic ld, input logic ul, input logic lifo,
                      input logic clr, input logic [DATA_W-1:0] src,
                      input string tag);
    bit ldE, ulE, errNew;
    @(negedge clk);
    loadStrobe = ld; unloadStrobe = ul; lifoMode = lifo;
    errClear = clr; srcWord = src;
    @(posedge clk);
    ldE = ld && !mPrevLd;
    ulE = ul && !mPrevUl;
    errNew = 0;
    if (ulE) begin
      if (q.size() == 0) errNew = 1;
      else if (lifo) mOut = q.pop_back();
      else mOut = q.pop_front();
    end
    if (ldE) begin
      if (q.size() == DEPTH) errNew = 1;
      else q.push_back(int'(src));
    end
    if (errNew) mErr = 1;
    else if (clr) mErr = 0;
    mPrevLd = ld; mPrevUl = ul;
    #2;
    checkAll(tag);
  endtask

  task automatic pulseLoad(input logic [DATA_W-1:0] w, input string tag);
    step(1, 0, 0, 0, w, tag);
    step(0, 0, 0, 0, '0, tag);
  endtask

  task automatic pulseUnload(input logic lifo, input string tag);
    step(0, 1, lifo, 0, '0, tag);
    step(0, 0, lifo, 0, '0, tag);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 checkAll("R1 reset state");

    // R3: fill ascending, full at DEPTH
    for (int k = 0; k < DEPTH; k++) pulseLoad(DATA_W'(16'h1100 + k), "R3 fill");
    // R6: store while full rejected
    pulseLoad(16'hDEAD, "R6 load when full");
    step(0, 0, 0, 0, '0, "R9 error held");
    step(0, 0, 0, 1, '0, "R9 error cleared");
    // R4: oldest first drain
    for (int k = 0; k < DEPTH; k++) pulseUnload(0, "R4 fifo drain");
    // R7: retrieval while empty
    pulseUnload(0, "R7 unload when empty");
    step(0, 0, 0, 0, '0, "R10 output held");
    step(0, 0, 0, 1, '0, "R9 clear");

    // R2: held strobe stores once
    step(1, 0, 0, 0, 16'hA001, "R2 load rise");
    step(1, 0, 0, 0, 16'hA002, "R2 load held");
    step(1, 0, 0, 0, 16'hA003, "R2 load held");
    step(0, 0, 0, 0, '0, "R2 release");
    pulseLoad(16'hA004, "R3 second");
    pulseLoad(16'hA005, "R3 third");
    // R5: newest first
    pulseUnload(1, "R5 lifo newest");
    step(0, 1, 1, 0, '0, "R2 unload rise");
    step(0, 1, 1, 0, '0, "R2 unload held");
    step(0, 0, 1, 0, '0, "R10 hold after unload");
    pulseUnload(1, "R5 lifo last");

    // R8: both edges, empty then mid then full
    step(1, 1, 0, 0, 16'hB001, "R8 both when empty");
    step(0, 0, 0, 1, '0, "R8 settle");
    for (int k = 0; k < DEPTH - 1; k++) pulseLoad(DATA_W'(16'hB010 + k), "R3 refill");
    step(1, 1, 0, 0, 16'hB0FF, "R8 both when full fifo");
    step(0, 0, 0, 0, '0, "R8 settle");
    step(1, 1, 1, 0, 16'hB0EE, "R8 both when full lifo");
    step(0, 0, 0, 0, '0, "R8 settle");
    // R11: mixed order
    pulseUnload(0, "R11 mixed fifo");
    pulseUnload(1, "R11 mixed lifo");
    pulseUnload(0, "R11 mixed fifo");
    // R9: rejection during clear keeps flag
    for (int k = 0; k < DEPTH; k++) pulseUnload(1, "R11 drain");
    step(0, 1, 0, 1, '0, "R9 set beats clear");
    step(0, 0, 0, 0, '0, "R9 still set");

    for (int k = 0; k < 600; k++)
      step(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
           DATA_W'($urandom), "R11 random");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule